// File: doc/BRIEF.md
# x86 Prefix and Opcode Pre-Decoder

This block sits at the front of an x86 instruction pipeline and takes instruction bytes one per cycle through a valid/ready handshake. It tracks the operand-size and address-size override prefixes, and in long mode the REX prefix. From these and two mode inputs it works out the effective operand and address sizes. The mode inputs are the default-size bit of the current code segment and a long-mode flag.

Each instruction's first opcode byte is placed in one of three classes: no-operation, software interrupt, or other. A software interrupt also takes the single immediate byte that follows its opcode as the 8-bit vector. For every instruction the block emits exactly one registered record. The record holds the two sizes, the class, the vector, and the number of bytes the instruction used, prefixes included. After each record the prefix state returns to empty, ready for the next instruction.

Top module: `insn_predecode`

## Requirements
- R1: Outside long mode, operand size is 16-bit when the default bit is 0 and 32-bit when it is 1; a 0x66 prefix selects the other of the two.
- R2: Outside long mode, address size follows the default bit in the same way (0 gives 16-bit, 1 gives 32-bit); a 0x67 prefix selects the other of the two.
- R3: Opcode 0x90 is reported as class NOP (code 1) in 16-bit and 32-bit code, with length equal to prefixes plus one.
- R4: In long mode, 0x90 is class NOP whether or not a 0x48 prefix comes just before it; the sequence 0x48 0x90 reports length 2 and operand size 64.
- R5: Opcode 0xCD is class software interrupt (code 2). Its record appears in the cycle after the following immediate byte is accepted, with that byte (0 to 255) as the vector and a length that counts the immediate.
- R6: Bytes 0x40 to 0x4F act as REX prefixes only when the long-mode flag is set; otherwise they are ordinary opcodes of class other. With REX bit 3 set, operand size is 64-bit (code 2), and this wins over 0x66.
- R7: In long mode, address size is 64-bit by default and 32-bit with 0x67; operand size is 32-bit by default and 16-bit with 0x66.
- R8: Repeating 0x66 or 0x67 has the same effect as a single one. A REX prefix counts only if it is the last byte before the opcode; otherwise it has no effect.
- R9: Any opcode other than 0x90 and 0xCD is class other (code 0), with vector 0, the computed sizes and the full byte count. Counts saturate at the largest value the length field holds.
- R10: Synchronous active-high reset clears all prefix state, deasserts the record strobe and holds ready low. Prefix state also clears after each record. The record strobe is high for exactly one cycle, in the cycle after the byte that completes the instruction is accepted. Size codes are 0 = 16-bit, 1 = 32-bit, 2 = 64-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cs_dflt32 | input | 1 | Code-segment default-size bit |
| long_mode | input | 1 | Long-mode flag |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_opsz | output | 2 | Operand size code |
| rec_adsz | output | 2 | Address size code |
| rec_class | output | 2 | Class code: 0 other, 1 NOP, 2 software interrupt |
| rec_vector | output | 8 | Interrupt vector, 0 for other classes |
| rec_len | output | LEN_W | Bytes used by the instruction |

## Verification
The reference model runs alongside the design and checks the record strobe on every clock, so a wrong internal state shows up as an early or missing strobe in the very cycle it would matter. An override flag stuck set or left set after a record shows as a wrong size code on the next instruction's record. A stale REX marker shows as a spurious 64-bit operand size. A lost wait-for-immediate state shows as a software interrupt reported one byte early, with the wrong vector and length.

// File: rtl/predec_pkg.sv
package predec_pkg;
  typedef enum logic [1:0] {SZ16 = 2'd0, SZ32 = 2'd1, SZ64 = 2'd2} size_e;
  typedef enum logic [1:0] {CL_OTHER = 2'd0, CL_NOP = 2'd1, CL_SWINT = 2'd2} iclass_e;
  localparam logic [7:0] BYTE_OPSZ  = 8'h66;
  localparam logic [7:0] BYTE_ADSZ  = 8'h67;
  localparam logic [7:0] BYTE_NOP   = 8'h90;
  localparam logic [7:0] BYTE_SWINT = 8'hCD;
  localparam logic [3:0] REX_NIBBLE = 4'h4;
  localparam int         REX_W_BIT  = 3;
endpackage

// File: rtl/predec_byteclass.sv
module predec_byteclass
  import predec_pkg::*;
(
  input  logic [7:0] b,
  input  logic       long_mode,
  output logic       is_opsz,
  output logic       is_adsz,
  output logic       is_rex,
  output logic       is_nop,
  output logic       is_swint
);
  always_comb begin
    is_opsz  = (b == BYTE_OPSZ);
    is_adsz  = (b == BYTE_ADSZ);
    is_rex   = long_mode && (b[7:4] == REX_NIBBLE);
    is_nop   = (b == BYTE_NOP);
    is_swint = (b == BYTE_SWINT);
  end
endmodule

// File: rtl/predec_size.sv
module predec_size
  import predec_pkg::*;
(
  input  logic  dflt32,
  input  logic  long_mode,
  input  logic  op_ovr,
  input  logic  ad_ovr,
  input  logic  rex_w,
  output size_e opsz,
  output size_e adsz
);
  always_comb begin
    if (long_mode) begin
      if (rex_w)       opsz = SZ64;
      else if (op_ovr) opsz = SZ16;
      else             opsz = SZ32;
      adsz = ad_ovr ? SZ32 : SZ64;
    end else begin
      opsz = (dflt32 ^ op_ovr) ? SZ32 : SZ16;
      adsz = (dflt32 ^ ad_ovr) ? SZ32 : SZ16;
    end
  end
endmodule

// File: rtl/insn_predecode.sv
module insn_predecode
  import predec_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  input  logic             cs_dflt32,
  input  logic             long_mode,
  output logic             rec_valid,
  output logic [1:0]       rec_opsz,
  output logic [1:0]       rec_adsz,
  output logic [1:0]       rec_class,
  output logic [7:0]       rec_vector,
  output logic [LEN_W-1:0] rec_len
);
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic             acc;
  logic             wait_imm, op_ovr, ad_ovr, rex_live, rex_wbit;
  logic [LEN_W-1:0] cnt, cnt_inc;
  size_e            held_opsz, held_adsz, cur_opsz, cur_adsz;
  logic             b_opsz, b_adsz, b_rex, b_nop, b_swint;

  assign in_ready = !rst;
  assign acc      = in_valid && in_ready;
  assign cnt_inc  = (cnt == LEN_MAX) ? cnt : cnt + 1'b1;

  predec_byteclass u_cls (
    .b(in_byte), .long_mode(long_mode),
    .is_opsz(b_opsz), .is_adsz(b_adsz), .is_rex(b_rex),
    .is_nop(b_nop), .is_swint(b_swint)
  );

  predec_size u_sz (
    .dflt32(cs_dflt32), .long_mode(long_mode),
    .op_ovr(op_ovr), .ad_ovr(ad_ovr), .rex_w(rex_live && rex_wbit),
    .opsz(cur_opsz), .adsz(cur_adsz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_imm   <= 1'b0;
      op_ovr     <= 1'b0;
      ad_ovr     <= 1'b0;
      rex_live   <= 1'b0;
      rex_wbit   <= 1'b0;
      cnt        <= '0;
      held_opsz  <= SZ16;
      held_adsz  <= SZ16;
      rec_valid  <= 1'b0;
      rec_opsz   <= 2'd0;
      rec_adsz   <= 2'd0;
      rec_class  <= 2'd0;
      rec_vector <= 8'd0;
      rec_len    <= '0;
    end else begin
      rec_valid <= 1'b0;
      if (acc) begin
        if (wait_imm) begin
          rec_valid  <= 1'b1;
          rec_opsz   <= held_opsz;
          rec_adsz   <= held_adsz;
          rec_class  <= CL_SWINT;
          rec_vector <= in_byte;
          rec_len    <= cnt_inc;
          wait_imm   <= 1'b0;
          op_ovr     <= 1'b0;
          ad_ovr     <= 1'b0;
          rex_live   <= 1'b0;
          cnt        <= '0;
        end else if (b_opsz) begin
          op_ovr   <= 1'b1;
          rex_live <= 1'b0;
          cnt      <= cnt_inc;
        end else if (b_adsz) begin
          ad_ovr   <= 1'b1;
          rex_live <= 1'b0;
          cnt      <= cnt_inc;
        end else if (b_rex) begin
          rex_live <= 1'b1;
          rex_wbit <= in_byte[REX_W_BIT];
          cnt      <= cnt_inc;
        end else if (b_swint) begin
          wait_imm  <= 1'b1;
          held_opsz <= cur_opsz;
          held_adsz <= cur_adsz;
          cnt       <= cnt_inc;
        end else begin
          rec_valid  <= 1'b1;
          rec_opsz   <= cur_opsz;
          rec_adsz   <= cur_adsz;
          rec_class  <= b_nop ? CL_NOP : CL_OTHER;
          rec_vector <= 8'd0;
          rec_len    <= cnt_inc;
          op_ovr     <= 1'b0;
          ad_ovr     <= 1'b0;
          rex_live   <= 1'b0;
          cnt        <= '0;
        end
      end
    end
  end

  // A 64-bit operand size only arises in long mode, where address size is never 16-bit.
  assert_rex_mode_R6: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_opsz == SZ64) |-> (rec_adsz != SZ16));

  // Every record counts at least its opcode byte.
  assert_len_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> (rec_len != '0));

  // An interrupt record covers opcode plus immediate.
  assert_swint_len_R5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_class == CL_SWINT) |-> (rec_len >= 2));

  // A record only follows an accepted byte.
  assert_strobe_cause_R10: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> $past(in_valid && in_ready));

  // Non-interrupt records carry a zero vector.
  assert_vector_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_class != CL_SWINT) |-> (rec_vector == 8'd0));
endmodule

// File: tb/insn_predecode_bench.sv
module insn_predecode_bench;
  localparam int LEN_W = 4;
  localparam int LMAX  = (1 << LEN_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'd0;
  logic in_ready;
  logic cs_dflt32 = 1'b0;
  logic long_mode = 1'b0;
  logic rec_valid;
  logic [1:0] rec_opsz, rec_adsz, rec_class;
  logic [7:0] rec_vector;
  logic [LEN_W-1:0] rec_len;

  always #4 clk = ~clk;

  insn_predecode #(.LEN_W(LEN_W)) u_insn_predecode (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .cs_dflt32(cs_dflt32), .long_mode(long_mode),
    .rec_valid(rec_valid), .rec_opsz(rec_opsz), .rec_adsz(rec_adsz),
    .rec_class(rec_class), .rec_vector(rec_vector), .rec_len(rec_len)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // behavioural model state
  int  m_cnt = 0;
  bit  m66 = 0, m67 = 0, mrex = 0, mrexw = 0, mwait = 0;
  int  m_hop = 0, m_had = 0;
  bit  e_valid; int e_op, e_ad, e_cls, e_vec, e_len;

  function automatic int m_opsize();
    if (long_mode) return (mrex && mrexw) ? 2 : (m66 ? 0 : 1);
    return (cs_dflt32 ^ m66) ? 1 : 0;
  endfunction
  function automatic int m_adsize();
    if (long_mode) return m67 ? 1 : 2;
    return (cs_dflt32 ^ m67) ? 1 : 0;
  endfunction
  function automatic int sat_inc(int c);
    return (c >= LMAX) ? LMAX : c + 1;
  endfunction

  task automatic m_clear();
    m_cnt = 0; m66 = 0; m67 = 0; mrex = 0; mwait = 0;
  endtask

  task automatic m_step(input logic [7:0] b);
    e_valid = 0;
    if (mwait) begin
      e_valid = 1; e_op = m_hop; e_ad = m_had; e_cls = 2; e_vec = b;
      e_len = sat_inc(m_cnt); m_clear();
    end else if (b == 8'h66) begin m66 = 1; mrex = 0; m_cnt = sat_inc(m_cnt); end
    else if (b == 8'h67) begin m67 = 1; mrex = 0; m_cnt = sat_inc(m_cnt); end
    else if (long_mode && b[7:4] == 4'h4) begin mrex = 1; mrexw = b[3]; m_cnt = sat_inc(m_cnt); end
    else if (b == 8'hCD) begin mwait = 1; m_hop = m_opsize(); m_had = m_adsize(); m_cnt = sat_inc(m_cnt); end
    else begin
      e_valid = 1; e_op = m_opsize(); e_ad = m_adsize(); e_cls = (b == 8'h90) ? 1 : 0;
      e_vec = 0; e_len = sat_inc(m_cnt); m_clear();
    end
  endtask

  task automatic check(input string tag);
    n_tests++;
    if (rec_valid !== e_valid) begin
      n_fail++;
      $display("FAIL %s rec_valid actual=%0d expected=%0d", tag, rec_valid, e_valid);
    end else if (e_valid && (rec_opsz !== e_op[1:0] || rec_adsz !== e_ad[1:0] ||
               rec_class !== e_cls[1:0] || rec_vector !== e_vec[7:0] || rec_len !== e_len[LEN_W-1:0])) begin
      n_fail++;
      $display("FAIL %s actual op=%0d ad=%0d cls=%0d vec=%0d len=%0d expected op=%0d ad=%0d cls=%0d vec=%0d len=%0d",
               tag, rec_opsz, rec_adsz, rec_class, rec_vector, rec_len, e_op, e_ad, e_cls, e_vec, e_len);
    end
  endtask

  // inputs change on negedge; record checked at the next negedge
  task automatic send(input logic [7:0] b, input string tag);
    in_valid = 1'b1; in_byte = b;
    m_step(b);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      e_valid = 0;
      @(posedge clk); @(negedge clk);
      check(tag);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_tests++;
    if (rec_valid !== 1'b0 || in_ready !== 1'b0) begin
      n_fail++; $display("FAIL R10 reset actual valid=%0d ready=%0d expected 0 0", rec_valid, in_ready);
    end
    rst = 1'b0;
    @(negedge clk);
    n_tests++;
    if (in_ready !== 1'b1) begin n_fail++; $display("FAIL R10 ready actual=%0d expected=1", in_ready); end
    idle(2, "R10 idle");

    // legacy, default 16-bit
    cs_dflt32 = 0; long_mode = 0;
    send(8'h90, "R3 nop16");
    send(8'h66, "R1 pfx"); send(8'h90, "R1 op toggle");
    send(8'h67, "R2 pfx"); send(8'h90, "R2 ad toggle");
    send(8'h66, "R8 pfx"); send(8'h66, "R8 pfx"); send(8'h67, "R8 pfx");
    send(8'h67, "R8 pfx"); send(8'h90, "R8 repeated");
    send(8'hCD, "R5 op"); send(8'h21, "R5 vec21");
    send(8'h48, "R6 legacy 48 other"); send(8'h90, "R6 legacy nop after 48");
    idle(1, "R10 gap");
    // legacy, default 32-bit
    cs_dflt32 = 1;
    send(8'h90, "R3 nop32");
    send(8'h66, "R1 pfx"); send(8'h67, "R2 pfx"); send(8'h90, "R1 R2 toggle32");
    send(8'h66, "R5 pfx"); send(8'hCD, "R5 op"); send(8'hFF, "R5 vecFF");
    send(8'hCD, "R5 op"); send(8'h00, "R5 vec00");
    send(8'h0F, "R9 other");
    // long mode
    long_mode = 1; cs_dflt32 = 0;
    send(8'h90, "R7 default");
    send(8'h48, "R4 rexw"); send(8'h90, "R4 rexw nop");
    send(8'h66, "R6 pfx"); send(8'h48, "R6 rex"); send(8'h90, "R6 rexw over 66");
    send(8'h48, "R8 rex"); send(8'h66, "R8 pfx"); send(8'h90, "R8 rex not last");
    send(8'h67, "R7 pfx"); send(8'h90, "R7 ad32");
    send(8'h66, "R7 pfx"); send(8'h90, "R7 op16");
    send(8'h40, "R6 rex no w"); send(8'h90, "R6 rex no w");
    send(8'h41, "R5 rex"); send(8'hCD, "R5 op"); send(8'h80, "R5 vec80 long");
    send(8'h4C, "R9 rex"); send(8'h8B, "R9 other long");
    // saturation
    for (int i = 0; i < LMAX + 2; i++) send(8'h66, "R9 pfx sat");
    send(8'h90, "R9 saturated len");
    // reset mid-instruction
    send(8'h66, "R10 pfx");
    rst = 1'b1; m_clear();
    idle(2, "R10 reset hold");
    rst = 1'b0;
    send(8'h90, "R10 cleared by reset");
    idle(2, "R10 tail");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule